// File: doc/BRIEF.md
# SIMD Floating-Point Exception Control Unit

This block works next to a floating-point or SIMD execution unit. Each operation that the datapath finishes hands over six condition bits together with its raw result. These are invalid operation, denormal operand, divide by zero, overflow, underflow and precision. For every raised condition the block looks up a per-condition mask in its control/status register. Masked conditions only leave a sticky status flag behind, and the operation still writes its destination. For a masked invalid operation or a masked divide by zero, the block swaps in a default value for the result. If any raised condition is unmasked, the destination write is dropped and a processor exception is signalled. The vector for that exception depends on an operating-system enable input.

The block also holds a floating-point-unavailable flag, which supports lazy context switching. Software sets it with one strobe and clears it with another. While it is set, any operation presented to the block traps with the device-unavailable vector before it takes effect. No flag changes and no destination is written. Once the flag is cleared, the same instruction can be presented again and it completes normally. All outputs are registered and appear one clock after the operation is presented.

Top module: `fpx_unit`

## Requirements
- R1: After reset the control/status read value is 0x1F80, which means all masks are set and all flags are clear. The unavailable flag is clear, and resValid and excValid are low.
- R2: The control/status register has flags in bits 0..5 and masks in bits 7..12. In both fields the bit order is invalid(0), denormal(1), divide-by-zero(2), overflow(3), underflow(4), precision(5). A write loads both fields. Bits 6 and 13..15 always read as zero.
- R3: An operation that raises only masked conditions gives resValid=1, resWrite=1 and excValid=0 in the next cycle. Its flags are ORed into the flag field. If neither invalid nor divide-by-zero is raised, resData equals the datapath result.
- R4: When invalid is raised and masked, resData is the quiet NaN 0x7FC00000 for the default 32-bit format. This holds even if divide-by-zero is raised in the same operation.
- R5: When divide-by-zero is raised and masked and invalid is not raised, resData is an infinity carrying the operation's sign: 0x7F800000 or 0xFF800000.
- R6: If any raised condition is unmasked and osEnable=1, then excValid=1 with excVector=19 and resWrite=0. Every raised condition, masked or not, sets its flag.
- R7: If any raised condition is unmasked and osEnable=0, then excValid=1 with excVector=6 and resWrite=0.
- R8: While the unavailable flag is set, every operation gives excValid=1, excVector=7 and resWrite=0, and the flags stay unchanged. This takes priority over all condition handling.
- R9: A pulse on unavailClr clears the unavailable flag, after which the same operation is handled normally. A pulse on unavailSet sets the flag. When both strobes arrive in the same cycle, the flag ends up set.
- R10: Flags are sticky. Only a register write lowers them. When a register write and an operation arrive in the same cycle, the operation's flags are ORed onto the written value, and the masks that were in force before the write decide the exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation completing this cycle |
| opCond | input | 6 | Condition bits raised by the operation |
| opSign | input | 1 | Sign used for a default infinity |
| opResult | input | 32 | Raw datapath result |
| osEnable | input | 1 | OS enable for the SIMD exception vector |
| unavailSet | input | 1 | Strobe that marks FP state unavailable |
| unavailClr | input | 1 | Strobe that marks FP state available |
| csrWrEn | input | 1 | Control/status register write strobe |
| csrWrData | input | 16 | Control/status register write value |
| csrRdData | output | 16 | Control/status register read value |
| resValid | output | 1 | Operation handled, one-cycle pulse |
| resWrite | output | 1 | Destination write enable |
| resData | output | 32 | Result to write |
| excValid | output | 1 | Exception raised, one-cycle pulse |
| excVector | output | 8 | Exception vector number |

## Verification
Directed cases present each condition alone and in pairs, under masks that are all set, all clear and mixed. Pairing invalid with divide-by-zero shows the result priority. Pairing a masked condition with an unmasked one shows that both flags are still recorded. Running the same unmasked operation with the OS enable set and then clear tells vector 19 apart from vector 6. An operation presented while the unavailable flag is set, followed by the same operation after the clear strobe, shows that the trap fires before execution and leaves the flags alone. Random sequences mix register writes, enable changes, unavailable strobes and sparse condition sets, so that sticky accumulation is checked across long runs.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NCOND    = 6;
  localparam int MASK_LSB = 7;
  localparam int CSR_W    = 16;
  localparam int VEC_W    = 8;

  localparam int CI_INV = 0;
  localparam int CI_DEN = 1;
  localparam int CI_DZ  = 2;
  localparam int CI_OVF = 3;
  localparam int CI_UNF = 4;
  localparam int CI_PRE = 5;

  localparam logic [VEC_W-1:0] VEC_UNDEF = 8'd6;
  localparam logic [VEC_W-1:0] VEC_NOFPU = 8'd7;
  localparam logic [VEC_W-1:0] VEC_SIMD  = 8'd19;

  typedef struct packed {
    logic             valid;
    logic             wrEn;
    logic             excEn;
    logic [VEC_W-1:0] excVec;
    logic             selQnan;
    logic             selInf;
  } fpxStrobe_t;
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [NCOND-1:0] opCond,
  input  logic             osEnable,
  input  logic             unavailSet,
  input  logic             unavailClr,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic [CSR_W-1:0] csrRdData,
  output fpxStrobe_t       strobe
);
  logic [NCOND-1:0] flagsQ, masksQ, opAcc, wrFlags, wrMasks;
  logic             unavailQ;
  logic             anyUnmasked;
  logic             unusedWr;

  assign unusedWr    = ^{csrWrData[CSR_W-1:MASK_LSB+NCOND], csrWrData[MASK_LSB-1:NCOND]};
  assign wrFlags     = csrWrData[NCOND-1:0];
  assign wrMasks     = csrWrData[MASK_LSB +: NCOND];
  assign anyUnmasked = |(opCond & ~masksQ);
  assign opAcc       = (opValid && !unavailQ) ? opCond : '0;

  always_comb begin
    strobe = '0;
    if (opValid) begin
      strobe.valid = 1'b1;
      if (unavailQ) begin
        strobe.excEn  = 1'b1;
        strobe.excVec = VEC_NOFPU;
      end else if (anyUnmasked) begin
        strobe.excEn  = 1'b1;
        strobe.excVec = osEnable ? VEC_SIMD : VEC_UNDEF;
      end else begin
        strobe.wrEn    = 1'b1;
        strobe.selQnan = opCond[CI_INV];
        strobe.selInf  = opCond[CI_DZ] & ~opCond[CI_INV];
      end
    end
  end

  for (genvar i = 0; i < NCOND; i++) begin : gCond
    always_ff @(posedge clk) begin
      if (!rstN) begin
        flagsQ[i] <= 1'b0;
        masksQ[i] <= 1'b1;
      end else begin
        flagsQ[i] <= (csrWrEn ? wrFlags[i] : flagsQ[i]) | opAcc[i];
        if (csrWrEn) masksQ[i] <= wrMasks[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           unavailQ <= 1'b0;
    else if (unavailSet) unavailQ <= 1'b1;
    else if (unavailClr) unavailQ <= 1'b0;
  end

  always_comb begin
    csrRdData = '0;
    csrRdData[NCOND-1:0]        = flagsQ;
    csrRdData[MASK_LSB +: NCOND] = masksQ;
  end

  // R8
  unavail_noflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && unavailQ && !csrWrEn) |=> $stable(flagsQ));

  // R10
  sticky_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> ((flagsQ & $past(flagsQ)) == $past(flagsQ)));

  // R9
  unavail_setwins_chk: assert property (@(posedge clk) disable iff (!rstN)
    unavailSet |=> unavailQ);
endmodule

// File: rtl/fpx_dpath.sv
module fpx_dpath
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WIDTH = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  fpxStrobe_t       strobe,
  input  logic             opSign,
  input  logic [WIDTH-1:0] opResult,
  output logic             resValid,
  output logic             resWrite,
  output logic [WIDTH-1:0] resData,
  output logic             excValid,
  output logic [VEC_W-1:0] excVector
);
  localparam logic [WIDTH-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [WIDTH-2:0] INFMAG = {{EXP_W{1'b1}}, {MAN_W{1'b0}}};

  logic [WIDTH-1:0] dataD;

  always_comb begin
    if (strobe.selQnan)     dataD = QNAN;
    else if (strobe.selInf) dataD = {opSign, INFMAG};
    else                    dataD = opResult;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resWrite  <= 1'b0;
      resData   <= '0;
      excValid  <= 1'b0;
      excVector <= '0;
    end else begin
      resValid  <= strobe.valid;
      resWrite  <= strobe.wrEn;
      excValid  <= strobe.excEn;
      excVector <= strobe.excEn ? strobe.excVec : '0;
      if (strobe.valid) resData <= dataD;
    end
  end

  // R6
  exc_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> !resWrite);

  // R7
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    excValid |-> (excVector == VEC_UNDEF || excVector == VEC_NOFPU || excVector == VEC_SIMD));

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resWrite || excValid) |-> resValid);
endmodule

// File: rtl/fpx_unit.sv
module fpx_unit
  import fpx_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WIDTH = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [NCOND-1:0] opCond,
  input  logic             opSign,
  input  logic [WIDTH-1:0] opResult,
  input  logic             osEnable,
  input  logic             unavailSet,
  input  logic             unavailClr,
  input  logic             csrWrEn,
  input  logic [CSR_W-1:0] csrWrData,
  output logic [CSR_W-1:0] csrRdData,
  output logic             resValid,
  output logic             resWrite,
  output logic [WIDTH-1:0] resData,
  output logic             excValid,
  output logic [VEC_W-1:0] excVector
);
  fpxStrobe_t strobe;

  fpx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCond(opCond),
    .osEnable(osEnable), .unavailSet(unavailSet), .unavailClr(unavailClr),
    .csrWrEn(csrWrEn), .csrWrData(csrWrData), .csrRdData(csrRdData),
    .strobe(strobe)
  );

  fpx_dpath #(.EXP_W(EXP_W), .MAN_W(MAN_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opSign(opSign),
    .opResult(opResult), .resValid(resValid), .resWrite(resWrite),
    .resData(resData), .excValid(excValid), .excVector(excVector)
  );
endmodule

// File: tb/sim_fpx_unit.sv
module sim_fpx_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [5:0]  opCond = '0;
  logic        opSign = 1'b0;
  logic [31:0] opResult = '0;
  logic        osEnable = 1'b1;
  logic        unavailSet = 1'b0;
  logic        unavailClr = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [15:0] csrWrData = '0;
  logic [15:0] csrRdData;
  logic        resValid, resWrite, excValid;
  logic [31:0] resData;
  logic [7:0]  excVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [5:0] mFlags = '0;
  logic [5:0] mMasks = 6'h3f;
  logic       mUnav  = 1'b0;

  fpx_unit u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCond(opCond), .opSign(opSign),
    .opResult(opResult), .osEnable(osEnable), .unavailSet(unavailSet),
    .unavailClr(unavailClr), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .csrRdData(csrRdData), .resValid(resValid), .resWrite(resWrite),
    .resData(resData), .excValid(excValid), .excVector(excVector)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] modelCsr();
    return {3'b000, mMasks, 1'b0, mFlags};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doOp(input logic [5:0] c, input logic s, input logic [31:0] r,
                      input string req, input logic wrCsr = 1'b0, input logic [15:0] wd = '0);
    logic eExc, eWr;
    logic [7:0] eVec;
    logic [31:0] eData;
    eExc = 1'b0; eWr = 1'b0; eVec = '0; eData = r;
    if (mUnav) begin
      eExc = 1'b1; eVec = 8'd7;
    end else if ((c & ~mMasks) != 0) begin
      eExc = 1'b1; eVec = osEnable ? 8'd19 : 8'd6;
    end else begin
      eWr = 1'b1;
      if (c[0])      eData = 32'h7FC00000;
      else if (c[2]) eData = {s, 31'h7F800000};
    end
    opValid = 1'b1; opCond = c; opSign = s; opResult = r;
    csrWrEn = wrCsr; csrWrData = wd;
    @(negedge clk);
    opValid = 1'b0; csrWrEn = 1'b0;
    if (wrCsr) begin
      mFlags = wd[5:0]; mMasks = wd[12:7];
    end
    if (!mUnav) mFlags = mFlags | c;
    chk({req, " resValid"}, 32'(resValid), 32'd1);
    chk({req, " excValid"}, 32'(excValid), 32'(eExc));
    if (eExc) chk({req, " excVector"}, 32'(excVector), 32'(eVec));
    chk({req, " resWrite"}, 32'(resWrite), 32'(eWr));
    if (eWr) chk({req, " resData"}, resData, eData);
    chk({req, " csr"}, 32'(csrRdData), 32'(modelCsr()));
  endtask

  task automatic csrWrite(input logic [15:0] wd);
    csrWrEn = 1'b1; csrWrData = wd;
    @(negedge clk);
    csrWrEn = 1'b0;
    mFlags = wd[5:0]; mMasks = wd[12:7];
  endtask

  task automatic unavPulse(input logic s, input logic c);
    unavailSet = s; unavailClr = c;
    @(negedge clk);
    unavailSet = 1'b0; unavailClr = 1'b0;
    if (s) mUnav = 1'b1;
    else if (c) mUnav = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 csr", 32'(csrRdData), 32'h1F80);
    chk("R1 excValid", 32'(excValid), 32'd0);
    chk("R1 resValid", 32'(resValid), 32'd0);
    doOp(6'b000000, 1'b0, 32'h3F800000, "R1 available");

    // R2 layout and reserved bits
    csrWrite(16'hFFFF);
    chk("R2 readback", 32'(csrRdData), 32'h1FBF);
    csrWrite(16'h1F80);
    chk("R2 restore", 32'(csrRdData), 32'h1F80);

    // R3 masked passthrough, R10 sticky
    doOp(6'b001000, 1'b0, 32'h12345678, "R3 overflow");
    doOp(6'b010000, 1'b1, 32'h00000001, "R10 sticky");
    chk("R10 accum", 32'(csrRdData), 32'h1F98);
    doOp(6'b100010, 1'b0, 32'hCAFEF00D, "R3 den+pre");
    csrWrite(16'h1F80);
    chk("R10 clear", 32'(csrRdData), 32'h1F80);

    // R4 / R5 default results
    doOp(6'b000101, 1'b1, 32'h11111111, "R4 inv+dz");
    doOp(6'b000001, 1'b0, 32'h22222222, "R4 inv");
    doOp(6'b000100, 1'b1, 32'h33333333, "R5 dz neg");
    doOp(6'b000100, 1'b0, 32'h44444444, "R5 dz pos");

    // R6 / R7 unmasked
    csrWrite(16'h1D80);
    osEnable = 1'b1;
    doOp(6'b100100, 1'b0, 32'h55555555, "R6 vec19");
    chk("R6 flags", 32'(csrRdData), 32'h1DA4);
    osEnable = 1'b0;
    doOp(6'b000100, 1'b0, 32'h55555555, "R7 vec6");
    doOp(6'b100000, 1'b0, 32'h66666666, "R7 masked ok");

    // R8 / R9 lazy trap
    csrWrite(16'h1D80);
    unavPulse(1'b1, 1'b0);
    doOp(6'b000100, 1'b0, 32'h77777777, "R8 trap");
    chk("R8 flags", 32'(csrRdData), 32'h1D80);
    doOp(6'b000000, 1'b0, 32'h77777777, "R8 clean trap");
    unavPulse(1'b1, 1'b1);
    doOp(6'b000000, 1'b0, 32'h77777777, "R9 set wins");
    unavPulse(1'b0, 1'b1);
    doOp(6'b000100, 1'b0, 32'h77777777, "R9 reexec");
    doOp(6'b000000, 1'b0, 32'h88888888, "R9 normal");

    // R10 same-cycle write and op: pre-write masks decide
    doOp(6'b000100, 1'b0, 32'h99999999, "R10 oldmask", 1'b1, 16'h1F80);
    doOp(6'b001000, 1'b0, 32'hAAAAAAAA, "R10 wr+op", 1'b1, 16'h1F80);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int k;
      k = int'($urandom % 10);
      if (k == 0)      csrWrite(16'($urandom));
      else if (k == 1) osEnable = $urandom % 2 == 1;
      else if (k == 2) unavPulse(1'b1, 1'b0);
      else if (k == 3) unavPulse(1'b0, 1'b1);
      else doOp(6'($urandom & $urandom & $urandom), 1'($urandom), $urandom, "R3 random");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule